// File: doc/BRIEF.md
# Parallel Port Strobe Handshake Controller

This block pairs an output port (B) with a bidirectional port (C) and adds a strobe pair that lets a peripheral exchange data with the CPU. An edge-sensitive strobe input (`stra`) and a strobe output (`strb`) either give simple latch-and-pulse signalling or run a full input or output handshake. In an input handshake the CPU reading the capture register signals "ready". In an output handshake the CPU writing Port C signals "data valid", and the level of `stra` can force Port C to drive.

A control register selects the mode and several options:
- interlocked or timed strobe,
- which `stra` edge is active,
- the `strb` polarity,
- an open-drain (wired-OR) style for Port C.

A status flag records each active `stra` edge and can raise an interrupt request. The strobe timer counts clock cycles qualified by the `e_en` enable. `stra` is expected to be synchronous to `clk`.

Top module: `ppio_hshake`

## Requirements
- R1: After reset the control register reads 0x02, Port B and all data registers are 0, `pc_oe` is 0, `irq` is 0 and `strb` is 1.
- R2: Register offsets on `addr`:
  - 0: control.
    - bit5: wired-OR.
    - bit4: handshake enable.
    - bit3: output-handshake select.
    - bit2: timed strobe.
    - bit1: rising active edge.
    - bit0: strobe active-high.
    - bits 7..6 read 0.
  - 1: Port B.
  - 2: Port C data. A read returns the pin for input bits and the register for driven bits.
  - 3: capture register, read-only.
  - 4: Port C direction, 1 = output.
  - 5: status.
    - bit0: flag, read-only.
    - bit1: interrupt enable.
  
  Writes take effect at the clock edge of the access cycle. Reads are combinational on `addr`.
- R3: Outside output handshake, an active `stra` edge copies `pc_in` into the capture register. The copy is visible one clock after the edge appears on the pin.
- R4: With handshake disabled, a write to Port B makes the strobe active for `PULSE_LEN` `e_en` cycles.
- R5: Control bit1 = 0 makes the falling `stra` edge active. Bit1 = 1 makes the rising edge active. The other edge has no effect.
- R6: In an input handshake (bit4 = 1, bit3 = 0), a read of offset 3 activates the strobe. In interlocked style (bit2 = 0) it stays active until the active `stra` edge.
- R7: In an output handshake (bit4 = 1, bit3 = 1), a write to offset 2 activates the strobe, and the active `stra` edge negates it. A trigger in the same cycle as an edge wins.
- R8: With bit2 = 1 in handshake mode, the strobe negates by itself after `PULSE_LEN` `e_en` cycles.
- R9: In an output handshake, `pc_oe` is all ones while `stra` differs from bit1. Otherwise it follows the direction register.
- R10: `strb` equals the strobe state when bit0 = 1, and its inverse when bit0 = 0.
- R11: With bit5 = 1, a Port C output bit drives 0 for a written 0 and releases (`pc_oe` = 0) for a written 1. With bit5 = 0, driven bits push the register value.
- R12: An active edge sets the flag. The flag clears only when a Port C access (offset 2 or 3) follows a read of offset 0 made while the flag was set. `irq` is the flag gated by the interrupt enable.
- R13: With bit4 = 0, bit3 has no effect: `stra` does not force Port C, and a Port C write does not activate the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e_en | input | 1 | E-clock enable for the strobe timer |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register offset |
| wdata | input | W | Write data |
| rdata | output | W | Read data |
| irq | output | 1 | Interrupt request |
| portb_out | output | W | Port B output |
| pc_in | input | W | Port C pin levels |
| pc_out | output | W | Port C output values |
| pc_oe | output | W | Port C per-bit drive enable |
| stra | input | 1 | Edge-sensitive strobe input |
| strb | output | 1 | Strobe output |

## Verification
The bench builds the block with `W` = 8 and `PULSE_LEN` = 2, and drives `e_en` high on every third clock. A timed strobe therefore spans several clocks, and the decrement being gated by `e_en` is visible. The narrow counter also reaches its terminal value quickly, so trigger-versus-edge priority and retriggering within one timed pulse both fall within short runs. A width of eight lets distinct per-bit patterns expose wired-OR release, forced direction and the mixed pin/register read of Port C.

// File: rtl/ppio_hshake.sv
module ppio_hshake #(
  parameter int W = 8,
  parameter int PULSE_LEN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         e_en,
  input  logic         cs,
  input  logic         we,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq,
  output logic [W-1:0] portb_out,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe,
  input  logic         stra,
  output logic         strb
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [2:0] A_CTL = 3'd0, A_PB = 3'd1, A_PC = 3'd2,
                         A_LAT = 3'd3, A_DDR = 3'd4, A_STS = 3'd5;

  logic [5:0]    ctl;
  logic [W-1:0]  pb, pc, lat, ddr;
  logic          staf, ie, arm, act, stra_d;
  logic [CW-1:0] cnt;

  wire wom  = ctl[5];
  wire hnds = ctl[4];
  wire oin  = ctl[3];
  wire pls  = ctl[2];
  wire ega  = ctl[1];
  wire invb = ctl[0];

  wire out_hs   = hnds & oin;
  wire rd       = cs & ~we;
  wire wr       = cs & we;
  wire edge_hit = ega ? (stra & ~stra_d) : (~stra & stra_d);
  wire force_out = out_hs & (stra ^ ega);
  wire [W-1:0] dir = ddr | {W{force_out}};
  wire pc_acc   = cs & ((addr == A_PC) | (addr == A_LAT));
  wire timed    = ~hnds | pls;
  wire trig     = hnds ? (oin ? (wr && addr == A_PC) : (rd && addr == A_LAT))
                       : (wr && addr == A_PB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= 6'b000010;
      pb     <= '0;
      pc     <= '0;
      ddr    <= '0;
      ie     <= 1'b0;
      stra_d <= 1'b0;
    end else begin
      stra_d <= stra;
      if (wr) begin
        case (addr)
          A_CTL:   ctl <= wdata[5:0];
          A_PB:    pb  <= wdata;
          A_PC:    pc  <= wdata;
          A_DDR:   ddr <= wdata;
          A_STS:   ie  <= wdata[1];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else if (edge_hit && !out_hs) lat <= pc_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staf <= 1'b0;
      arm  <= 1'b0;
    end else begin
      if (edge_hit) staf <= 1'b1;
      else if (arm && pc_acc) staf <= 1'b0;
      if (rd && addr == A_CTL && staf) arm <= 1'b1;
      else if (pc_acc) arm <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (trig) begin
      act <= 1'b1;
      cnt <= CW'(PULSE_LEN);
    end else if (edge_hit) begin
      act <= 1'b0;
    end else if (act && timed && e_en) begin
      if (cnt <= 1) act <= 1'b0;
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = W'(ctl);
      A_PB:    rdata = pb;
      A_PC:    rdata = (dir & pc) | (~dir & pc_in);
      A_LAT:   rdata = lat;
      A_DDR:   rdata = ddr;
      A_STS:   rdata = W'({ie, staf});
      default: rdata = '0;
    endcase
  end

  assign portb_out = pb;
  assign pc_oe     = dir & (wom ? ~pc : '1);
  assign pc_out    = wom ? '0 : pc;
  assign strb      = invb ? act : ~act;
  assign irq       = staf & ie;
endmodule

// File: rtl/ppio_hshake_chk.sv
module ppio_hshake_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [5:0]   ctl,
  input logic         stra,
  input logic         edge_hit,
  input logic         trig,
  input logic         staf,
  input logic         act,
  input logic [W-1:0] lat,
  input logic [W-1:0] pc,
  input logic [W-1:0] pc_oe
);
  // R11
  wom_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[5] |-> ((pc_oe & pc) == '0));

  // R9
  force_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[4] && ctl[3] && (stra ^ ctl[1]) && !ctl[5]) |-> (pc_oe == '1));

  // R12
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(staf) |-> $past(edge_hit));

  // R7
  trigger_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> act);

  // R6
  interlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ctl[4] && !ctl[2] && !trig && !edge_hit) |=> act);

  // R3
  capture_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_hit |=> $stable(lat));
endmodule

bind ppio_hshake ppio_hshake_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .stra(stra), .edge_hit(edge_hit),
  .trig(trig), .staf(staf), .act(act), .lat(lat), .pc(pc), .pc_oe(pc_oe)
);

// File: tb/tb_ppio_hshake.sv
module tb_ppio_hshake;
  localparam int W = 8;
  localparam int PULSE_LEN = 2;

  logic clk = 0, rst_n = 0, e_en = 0, cs = 0, we = 0, stra = 0;
  logic [2:0] addr = 0;
  logic [W-1:0] wdata = 0, pc_in = 0;
  logic [W-1:0] rdata, portb_out, pc_out, pc_oe;
  logic irq, strb;

  ppio_hshake #(.W(W), .PULSE_LEN(PULSE_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .e_en(e_en), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .portb_out(portb_out),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe), .stra(stra), .strb(strb));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, ecnt = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] actv, logic [31:0] expv);
    n_chk++;
    if (actv !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, actv, expv);
    end
  endtask

  always @(posedge clk) begin
    #1;
    ecnt++;
    e_en = (ecnt % 3 == 0);
  end

  // reference model
  logic [5:0] m_ctl;
  logic [W-1:0] m_pb, m_pc, m_lat, m_ddr;
  bit m_staf, m_ie, m_arm, m_act, m_sp;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 6'h02; m_pb = 0; m_pc = 0; m_lat = 0; m_ddr = 0;
      m_staf = 0; m_ie = 0; m_arm = 0; m_act = 0; m_sp = 0; m_cnt = 0;
    end else begin
      bit hit, trg, n_staf, n_arm, pacc, rdc, wrc;
      rdc = cs && !we;
      wrc = cs && we;
      hit = m_ctl[1] ? (stra && !m_sp) : (!stra && m_sp);
      pacc = cs && (addr == 2 || addr == 3);
      if (!m_ctl[4]) trg = wrc && addr == 1;
      else if (m_ctl[3]) trg = wrc && addr == 2;
      else trg = rdc && addr == 3;
      n_staf = m_staf; n_arm = m_arm;
      if (hit) n_staf = 1; else if (m_arm && pacc) n_staf = 0;
      if (rdc && addr == 0 && m_staf) n_arm = 1; else if (pacc) n_arm = 0;
      if (hit && !(m_ctl[4] && m_ctl[3])) m_lat = pc_in;
      if (trg) begin m_act = 1; m_cnt = PULSE_LEN; end
      else if (hit) m_act = 0;
      else if (m_act && (!m_ctl[4] || m_ctl[2]) && e_en) begin
        m_cnt = m_cnt - 1;
        if (m_cnt <= 0) m_act = 0;
      end
      m_staf = n_staf; m_arm = n_arm; m_sp = stra;
      if (wrc) begin
        if (addr == 0) m_ctl = wdata[5:0];
        else if (addr == 1) m_pb = wdata;
        else if (addr == 2) m_pc = wdata;
        else if (addr == 4) m_ddr = wdata;
        else if (addr == 5) m_ie = wdata[1];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [W-1:0] edir, eoe, eout, erd;
      for (int i = 0; i < W; i++) begin
        edir[i] = m_ddr[i] || (m_ctl[4] && m_ctl[3] && (stra != m_ctl[1]));
        eoe[i]  = edir[i] && !(m_ctl[5] && m_pc[i]);
        eout[i] = m_ctl[5] ? 1'b0 : m_pc[i];
      end
      case (addr)
        0: erd = W'(m_ctl);
        1: erd = m_pb;
        2: for (int i = 0; i < W; i++) erd[i] = edir[i] ? m_pc[i] : pc_in[i];
        3: erd = m_lat;
        4: erd = m_ddr;
        5: erd = W'({m_ie, m_staf});
        default: erd = 0;
      endcase
      check("R10 strb model", strb, m_ctl[0] ? m_act : !m_act);
      check("R12 irq model", irq, m_staf && m_ie);
      check("R2 portb model", portb_out, m_pb);
      check("R11 pc_out model", pc_out, eout);
      check("R9 pc_oe model", pc_oe, eoe);
      check("R2 rdata model", rdata, erd);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    cyc(); cs = 1; we = 1; addr = a; wdata = d;
    cyc(); cs = 0; we = 0;
  endtask
  task automatic rd(input logic [2:0] a);
    cyc(); cs = 1; we = 0; addr = a;
    cyc(); cs = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) cyc();
  endtask
  task automatic set_stra(input logic v);
    cyc(); stra = v;
  endtask
  task automatic chk_rd(input logic [2:0] a, input logic [W-1:0] e, input string tag);
    cyc(); cs = 0; addr = a;
    @(negedge clk);
    check(tag, rdata, e);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 ctl reset", rdata, 8'h02);
    check("R1 strb reset", strb, 1);
    check("R1 portb reset", portb_out, 0);
    check("R1 pc_oe reset", pc_oe, 0);
    check("R1 irq reset", irq, 0);
    cyc(); rst_n = 1;

    wr(4, 8'hF0); chk_rd(4, 8'hF0, "R2 ddr readback");
    wr(0, 8'hFF); chk_rd(0, 8'h3F, "R2 ctl upper bits zero");
    wr(0, 8'h02); wr(4, 8'h00);

    pc_in = 8'h5A; set_stra(1); idle(2); chk_rd(3, 8'h5A, "R3 capture on rising");
    pc_in = 8'h11; set_stra(0); idle(2); chk_rd(3, 8'h5A, "R5 falling ignored");
    wr(0, 8'h00); pc_in = 8'h33;
    set_stra(1); idle(2); set_stra(0); idle(2);
    chk_rd(3, 8'h33, "R5 falling active");

    @(negedge clk); check("R10 inactive high", strb, 1);
    wr(0, 8'h03); wr(1, 8'hA5);
    @(negedge clk); check("R4 strobe on portb write", strb, 1);
    check("R4 portb value", portb_out, 8'hA5);
    idle(20); @(negedge clk); check("R4 strobe ends", strb, 0);

    wr(0, 8'h13); rd(3);
    @(negedge clk); check("R6 ready on capture read", strb, 1);
    idle(10); @(negedge clk); check("R6 held interlocked", strb, 1);
    set_stra(1); idle(1); @(negedge clk); check("R6 negated by edge", strb, 0);

    set_stra(0); wr(0, 8'h1B);
    @(negedge clk); check("R9 forced drive", pc_oe, 8'hFF);
    wr(2, 8'h3C);
    @(negedge clk); check("R7 strobe on portc write", strb, 1);
    check("R7 data out", pc_out, 8'h3C);
    set_stra(1); idle(1); @(negedge clk);
    check("R7 acknowledged", strb, 0);
    check("R9 follows ddr", pc_oe, 8'h00);

    wr(0, 8'h1F); wr(2, 8'hC3);
    @(negedge clk); check("R8 timed start", strb, 1);
    idle(12); @(negedge clk); check("R8 timed end", strb, 0);

    wr(0, 8'h22); wr(4, 8'hFF); wr(2, 8'h0F);
    @(negedge clk); check("R11 release ones", pc_oe, 8'hF0);
    check("R11 drive zeros", pc_out, 8'h00);
    wr(0, 8'h02);
    @(negedge clk); check("R11 push-pull", pc_out, 8'h0F);

    rd(0); rd(2); wr(5, 8'h02);
    @(negedge clk); check("R12 flag cleared first", irq, 0);
    set_stra(0); set_stra(1); idle(1);
    @(negedge clk); check("R12 set by edge", irq, 1);
    rd(2); @(negedge clk); check("R12 not armed", irq, 1);
    rd(0); rd(2); @(negedge clk); check("R12 cleared", irq, 0);

    wr(0, 8'h0A); wr(4, 8'h00); set_stra(0); idle(1);
    @(negedge clk); check("R13 no forced drive", pc_oe, 8'h00);
    wr(2, 8'h55);
    @(negedge clk); check("R13 no strobe", strb, 1);

    idle(5);
    finish_run();
  end
endmodule